// File: doc/BRIEF.md
# Serial Flash Status Register Write Handler

This block is the device-side receiver for the command that rewrites the two 8-bit status registers of a serial flash. It samples chip-select, the serial clock and four data lines with the device's own system clock. It accepts the command either one bit per serial clock on IO0 or one nibble per serial clock on IO3..IO0. When chip-select rises after a complete frame, it commits the new register values.

There are two commit paths. A persistent write needs the write-enable latch to be set. It raises BUSY for a programmable number of cycles, then applies the new values and clears the latch. A temporary write is armed by a one-byte 50h prefix sent just before it. It does not need the latch, keeps BUSY low, and applies the values after a short programmable refresh delay.

While the nibble-wide lane format is active, the quad-enable bit of the second register is protected and cannot change. Other logic in the device sets the write-enable latch with a one-cycle pulse. This block clears the latch.

Top module: `srw_top`

## Requirements
- R1: After reset, both status registers read 0x00, and BUSY and WEL read 0.
- R2: With `quad_i`=0, the frame arrives on IO0, most significant bit first, as opcode 01h, then the first register byte, then the second register byte (24 serial clocks). A persistent write of that frame loads both registers.
- R3: With `quad_i`=1, each byte takes two serial clocks on IO3..IO0 with the high nibble first (IO3 carries bit 7 and then bit 3). The full frame is 6 serial clocks.
- R4: A persistent write raises BUSY within 3 system clocks of chip-select rising. Both registers keep their old values while BUSY is 1. BUSY falls after NV_CYC cycles, in the same cycle that the new values appear.
- R5: A persistent write is committed only when WEL is 1. WEL reads 0 once the busy cycle ends.
- R6: When a 50h prefix (8 serial clocks, then chip-select high) comes just before the write, the write is temporary. It needs no WEL, it leaves WEL unchanged, BUSY stays 0 throughout, and the values appear within VOL_CYC+4 cycles of chip-select rising.
- R7: The prefix is used up by the next command with at least one serial clock, whatever that command is. A write that follows an intervening command is treated as persistent.
- R8: While `quad_i`=1, the quad-enable bit (bit QE_BIT of the second register, default bit 1) keeps its value even when the frame carries a different value.
- R9: A frame ignored while BUSY or a refresh is pending leaves the registers and WEL unchanged. So does a frame whose bit count is not 16 or 24 when chip-select rises.
- R10: A frame that ends after 16 serial-clock bits (opcode plus one byte) updates only the first register. The second register keeps its value.
- R11: A one-cycle pulse on `wel_set_i` sets WEL while BUSY is 0.
- R12: A frame whose opcode is not 01h changes no register and leaves WEL as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that samples all serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip-select, active low |
| sck_i | input | 1 | Serial clock; data is sampled on its rising edge |
| io_i | input | 4 | Data lines IO3..IO0 |
| quad_i | input | 1 | 1 selects the nibble-wide lane format |
| wel_set_i | input | 1 | One-cycle request to set the write-enable latch |
| sr1_o | output | 8 | First status register |
| sr2_o | output | 8 | Second status register |
| busy_o | output | 1 | Persistent write cycle in progress |
| wel_o | output | 1 | Write-enable latch |

## Verification
A wrong bit counter or a wrong lane shift shows up as a wrong register value once the commit completes. It can also show up as a missing commit, which leaves the registers, BUSY and WEL at their old values from 3 cycles after chip-select rises. A stuck prefix flag turns a later persistent write into a temporary one. That is visible because BUSY never rises and WEL is not cleared. A timer fault shows as a BUSY window of the wrong length, or as BUSY rising during a temporary write. A broken quad-enable guard shows as a changed bit 1 of the second register at the end of a nibble-wide write.

// File: rtl/srw_pkg.sv
package srw_pkg;

  localparam int FRAME_BITS = 24;
  localparam int CNT_W      = 6;

  localparam logic [7:0] OPC_WRITE_SR = 8'h01;
  localparam logic [7:0] OPC_VOL_PFX  = 8'h50;

  typedef enum logic [1:0] {
    JOB_NONE = 2'd0,
    JOB_NV   = 2'd1,
    JOB_VOL  = 2'd2
  } job_e;

  // Shift one serial clock of data into the frame register.
  function automatic logic [FRAME_BITS-1:0] lane_shift(
    input logic [FRAME_BITS-1:0] sh,
    input logic [3:0]            io,
    input logic                  quad
  );
    if (quad) return {sh[FRAME_BITS-5:0], io};
    return {sh[FRAME_BITS-2:0], io[0]};
  endfunction

  // Number of frame bits received per serial clock.
  function automatic logic [CNT_W-1:0] lane_step(input logic quad);
    return quad ? CNT_W'(4) : CNT_W'(1);
  endfunction

  // Keep the quad-enable bit when writing in nibble-wide mode.
  function automatic logic [7:0] qe_guard(
    input logic [7:0] old_v,
    input logic [7:0] new_v,
    input logic       quad,
    input int         qe_bit
  );
    logic [7:0] r;
    r = new_v;
    if (quad) r[qe_bit] = old_v[qe_bit];
    return r;
  endfunction

endpackage

// File: rtl/srw_lane_rx.sv
module srw_lane_rx
  import srw_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cs_ni,
  input  logic                  sck_i,
  input  logic [3:0]            io_i,
  input  logic                  quad_i,
  output logic                  cs_rise_o,
  output logic [FRAME_BITS-1:0] shreg_o,
  output logic [CNT_W-1:0]      bits_o
);

  logic       cs_q, cs_d;
  logic       sck_q, sck_d;
  logic [3:0] io_q;
  logic       sck_rise, cs_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= 1'b1;
      cs_d  <= 1'b1;
      sck_q <= 1'b0;
      sck_d <= 1'b0;
      io_q  <= '0;
    end else begin
      cs_q  <= cs_ni;
      cs_d  <= cs_q;
      sck_q <= sck_i;
      sck_d <= sck_q;
      io_q  <= io_i;
    end
  end

  assign sck_rise  = sck_q & ~sck_d & ~cs_q;
  assign cs_fall   = ~cs_q & cs_d;
  assign cs_rise_o = cs_q & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_o <= '0;
      bits_o  <= '0;
    end else if (cs_fall) begin
      shreg_o <= '0;
      bits_o  <= '0;
    end else if (sck_rise) begin
      shreg_o <= lane_shift(shreg_o, io_q, quad_i);
      if (bits_o <= CNT_W'(FRAME_BITS)) bits_o <= bits_o + lane_step(quad_i);
    end
  end

endmodule

// File: rtl/srw_decode.sv
module srw_decode
  import srw_pkg::*;
(
  input  logic                  cs_rise_i,
  input  logic [FRAME_BITS-1:0] shreg_i,
  input  logic [CNT_W-1:0]      bits_i,
  input  logic                  wel_i,
  input  logic                  busy_i,
  input  logic                  refresh_i,
  input  logic                  armed_i,
  output logic                  commit_nv_o,
  output logic                  commit_vol_o,
  output logic                  arm_o,
  output logic                  disarm_o,
  output logic [7:0]            new_sr1_o,
  output logic [7:0]            new_sr2_o,
  output logic                  has_sr2_o
);

  logic       full, half, idle, is_write, is_pfx;
  logic [7:0] opc;

  assign full = (bits_i == CNT_W'(FRAME_BITS));
  assign half = (bits_i == CNT_W'(FRAME_BITS - 8));
  assign idle = ~busy_i & ~refresh_i;

  always_comb begin
    if (full)      opc = shreg_i[23:16];
    else if (half) opc = shreg_i[15:8];
    else           opc = shreg_i[7:0];
  end

  assign is_write = cs_rise_i & (full | half) & (opc == OPC_WRITE_SR) & idle;
  assign is_pfx   = cs_rise_i & (bits_i == CNT_W'(8)) & (shreg_i[7:0] == OPC_VOL_PFX) & idle;

  assign commit_vol_o = is_write & armed_i;
  assign commit_nv_o  = is_write & ~armed_i & wel_i;
  assign arm_o        = is_pfx;
  assign disarm_o     = cs_rise_i & (bits_i != '0) & ~is_pfx;

  assign new_sr1_o = full ? shreg_i[15:8] : shreg_i[7:0];
  assign new_sr2_o = shreg_i[7:0];
  assign has_sr2_o = full;

endmodule

// File: rtl/srw_timer.sv
module srw_timer
  import srw_pkg::*;
#(
  parameter int NV_CYC  = 2000,
  parameter int VOL_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  job_e kind_i,
  output logic busy_o,
  output logic refresh_o,
  output logic done_o,
  output job_e done_kind_o
);

  localparam int MAXC = (NV_CYC > VOL_CYC) ? NV_CYC : VOL_CYC;
  localparam int W    = $clog2(MAXC + 1);
  localparam logic [W-1:0] NV_LOAD  = W'(NV_CYC - 1);
  localparam logic [W-1:0] VOL_LOAD = W'(VOL_CYC - 1);

  logic [W-1:0] cnt;
  job_e         job;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt <= '0;
      job <= JOB_NONE;
    end else if (start_i && job == JOB_NONE) begin
      job <= kind_i;
      cnt <= (kind_i == JOB_NV) ? NV_LOAD : VOL_LOAD;
    end else if (job != JOB_NONE) begin
      if (cnt == '0) job <= JOB_NONE;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign busy_o      = (job == JOB_NV);
  assign refresh_o   = (job == JOB_VOL);
  assign done_o      = (job != JOB_NONE) && (cnt == '0);
  assign done_kind_o = job;

endmodule

// File: rtl/srw_top.sv
module srw_top
  import srw_pkg::*;
#(
  parameter int NV_CYC  = 2000,
  parameter int VOL_CYC = 16,
  parameter int QE_BIT  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic [3:0] io_i,
  input  logic       quad_i,
  input  logic       wel_set_i,
  output logic [7:0] sr1_o,
  output logic [7:0] sr2_o,
  output logic       busy_o,
  output logic       wel_o
);

  logic                  cs_rise;
  logic [FRAME_BITS-1:0] shreg;
  logic [CNT_W-1:0]      bits;
  logic                  commit_nv, commit_vol, arm, disarm, has_sr2;
  logic [7:0]            new_sr1, new_sr2;
  logic                  refresh, apply;
  job_e                  done_kind;
  logic                  armed;
  logic [7:0]            pend1, pend2;
  logic                  pend_has2;

  srw_lane_rx u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sck_i    (sck_i),
    .io_i     (io_i),
    .quad_i   (quad_i),
    .cs_rise_o(cs_rise),
    .shreg_o  (shreg),
    .bits_o   (bits)
  );

  srw_decode u_dec (
    .cs_rise_i   (cs_rise),
    .shreg_i     (shreg),
    .bits_i      (bits),
    .wel_i       (wel_o),
    .busy_i      (busy_o),
    .refresh_i   (refresh),
    .armed_i     (armed),
    .commit_nv_o (commit_nv),
    .commit_vol_o(commit_vol),
    .arm_o       (arm),
    .disarm_o    (disarm),
    .new_sr1_o   (new_sr1),
    .new_sr2_o   (new_sr2),
    .has_sr2_o   (has_sr2)
  );

  srw_timer #(.NV_CYC(NV_CYC), .VOL_CYC(VOL_CYC)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (commit_nv | commit_vol),
    .kind_i     (commit_vol ? JOB_VOL : JOB_NV),
    .busy_o     (busy_o),
    .refresh_o  (refresh),
    .done_o     (apply),
    .done_kind_o(done_kind)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend1     <= '0;
      pend2     <= '0;
      pend_has2 <= 1'b0;
    end else if (commit_nv | commit_vol) begin
      pend1     <= new_sr1;
      pend2     <= qe_guard(sr2_o, new_sr2, quad_i, QE_BIT);
      pend_has2 <= has_sr2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr1_o <= '0;
      sr2_o <= '0;
    end else if (apply) begin
      sr1_o <= pend1;
      if (pend_has2) sr2_o <= pend2;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             wel_o <= 1'b0;
    else if (apply && done_kind == JOB_NV)   wel_o <= 1'b0;
    else if (wel_set_i && !busy_o)           wel_o <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     armed <= 1'b0;
    else if (arm)    armed <= 1'b1;
    else if (disarm) armed <= 1'b0;
  end

endmodule

// File: rtl/srw_checker.sv
module srw_checker #(
  parameter int QE_BIT = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       quad_i,
  input logic       busy_o,
  input logic       wel_o,
  input logic [7:0] sr1_o,
  input logic [7:0] sr2_o,
  input logic       commit_nv,
  input logic       commit_vol,
  input logic       refresh,
  input logic       apply
);

  a_r4_busy_follows_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_nv |=> busy_o);

  a_r6_refresh_not_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    refresh |-> !busy_o);

  a_r5_wel_clear_at_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !wel_o);

  a_r8_qe_held_in_quad: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quad_i && $past(quad_i)) |-> $stable(sr2_o[QE_BIT]));

  a_r9_no_commit_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o || refresh) |-> !(commit_nv || commit_vol));

  a_r2_regs_change_on_apply: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({sr1_o, sr2_o}) |-> $past(apply));

endmodule

bind srw_top srw_checker #(.QE_BIT(QE_BIT)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .quad_i    (quad_i),
  .busy_o    (busy_o),
  .wel_o     (wel_o),
  .sr1_o     (sr1_o),
  .sr2_o     (sr2_o),
  .commit_nv (commit_nv),
  .commit_vol(commit_vol),
  .refresh   (refresh),
  .apply     (apply)
);

// File: tb/srw_top_tb_top.sv
`timescale 1ns/1ps
module srw_top_tb_top;

  localparam int NV  = 400;
  localparam int VOL = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1;
  logic       sck = 1'b0;
  logic [3:0] io = '0;
  logic       quad = 1'b0;
  logic       wel_set = 1'b0;
  logic [7:0] sr1, sr2;
  logic       busy, wel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  srw_top #(.NV_CYC(NV), .VOL_CYC(VOL), .QE_BIT(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .io_i(io),
    .quad_i(quad), .wel_set_i(wel_set), .sr1_o(sr1), .sr2_o(sr2),
    .busy_o(busy), .wel_o(wel)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sck_pulse();
    repeat (4) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  // Send the low nbits of d, most significant first, in the current lane format.
  task automatic send(input logic [23:0] d, input int nbits);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    if (quad) begin
      for (int i = nbits / 4 - 1; i >= 0; i--) begin
        io = d[i*4 +: 4];
        sck_pulse();
      end
    end else begin
      for (int i = nbits - 1; i >= 0; i--) begin
        io = {3'b000, d[i]};
        sck_pulse();
      end
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic set_wel();
    @(negedge clk);
    wel_set = 1'b1;
    @(negedge clk);
    wel_set = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_nv();
    repeat (NV + 10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 regs", {sr1, sr2}, 16'h0000);
    chk("R1 busy/wel", {14'd0, busy, wel}, 16'h0000);
  endtask

  task automatic t_nv_without_wel();
    send(24'h01AA55, 24);
    wait_nv();
    chk("R5 no-wel write ignored", {sr1, sr2}, 16'h0000);
    chk("R5 busy stays low", {15'd0, busy}, 16'h0000);
  endtask

  task automatic t_wel_set();
    set_wel();
    chk("R11 wel set", {15'd0, wel}, 16'h0001);
  endtask

  task automatic t_spi_nv();
    send(24'h01A53C, 24);
    chk("R4 busy high", {15'd0, busy}, 16'h0001);
    chk("R4 old values during busy", {sr1, sr2}, 16'h0000);
    wait_nv();
    chk("R4 busy low at end", {15'd0, busy}, 16'h0000);
    chk("R2 spi write", {sr1, sr2}, 16'hA53C);
    chk("R5 wel cleared", {15'd0, wel}, 16'h0000);
  endtask

  task automatic t_busy_ignore();
    set_wel();
    send(24'h011122, 24);
    set_wel();
    send(24'h01FFFF, 24);
    chk("R9 still busy", {15'd0, busy}, 16'h0001);
    wait_nv();
    chk("R9 write while busy ignored", {sr1, sr2}, 16'h1122);
    chk("R11 pulse during busy ignored", {15'd0, wel}, 16'h0000);
  endtask

  task automatic t_quad_nv();
    quad = 1'b1;
    set_wel();
    send(24'h01C35C, 24);
    chk("R3 busy in quad", {15'd0, busy}, 16'h0001);
    wait_nv();
    chk("R3 quad sr1", {8'h00, sr1}, 16'h00C3);
    chk("R8 qe kept", {8'h00, sr2}, 16'h005E);
    quad = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_volatile();
    int hi;
    send(24'h000050, 8);
    @(negedge clk);
    cs_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 23; i >= 0; i--) begin
      io = {3'b000, logic'(24'h010FF0 >> i)};
      sck_pulse();
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    hi = 0;
    for (int i = 0; i < VOL + 4; i++) begin
      @(negedge clk);
      if (busy) hi++;
    end
    chk("R6 busy stays low", 16'(hi), 16'h0000);
    chk("R6 volatile values", {sr1, sr2}, 16'h0FF0);
    chk("R6 wel untouched", {15'd0, wel}, 16'h0000);
  endtask

  task automatic t_stale_prefix();
    send(24'h000050, 8);
    send(24'h000006, 8);
    send(24'h017788, 24);
    wait_nv();
    chk("R7 prefix consumed", {sr1, sr2}, 16'h0FF0);
    chk("R7 no busy without wel", {15'd0, busy}, 16'h0000);
  endtask

  task automatic t_partial();
    set_wel();
    send(24'h001ABC, 20);
    wait_nv();
    chk("R9 partial frame ignored", {sr1, sr2}, 16'h0FF0);
    chk("R9 wel kept", {15'd0, wel}, 16'h0001);
  endtask

  task automatic t_sr1_only();
    send(24'h000196, 16);
    wait_nv();
    chk("R10 sr1 only", {sr1, sr2}, 16'h96F0);
    chk("R10 wel cleared", {15'd0, wel}, 16'h0000);
  endtask

  task automatic t_bad_opcode();
    set_wel();
    send(24'h021234, 24);
    wait_nv();
    chk("R12 wrong opcode", {sr1, sr2}, 16'h96F0);
    chk("R12 wel kept", {14'd0, busy, wel}, 16'h0001);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_nv_without_wel();
    t_wel_set();
    t_spi_nv();
    t_busy_ignore();
    t_quad_nv();
    t_volatile();
    t_stale_prefix();
    t_partial();
    t_sr1_only();
    t_bad_opcode();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule